// File: doc/BRIEF.md
# Calendar Validator and BCD Codec

This block sits between software-facing binary time values and a battery-backed timekeeper that stores its fields as packed BCD with a two-digit year. On the encode side a caller presents a full binary year, a zero-based month, a day, an hour, a minute and a second together with a strobe. The block checks that the date and time are legal and, if they are, converts every field into packed BCD. The year is folded into two digits using a windowed century. If any field is illegal, the block raises an error flag and leaves its stored BCD values untouched.

The decode side performs the reverse step. It takes the six BCD register values read back from the timekeeper and returns binary fields. The two-digit year is expanded to a full year using the same century window, and the month is returned zero-based. Both paths register their outputs and add one cycle of latency. The two paths are independent and may be used in the same cycle.

Top module: `cal_bcd_codec`

## Requirements
- R1: `enc_valid_o` is high in exactly the cycle after a cycle in which `enc_valid_i` is high, and low otherwise. `dec_valid_o` follows `dec_valid_i` with the same single cycle of latency.
- R2: A year below 1970 or above 2069 makes the encode result an error.
- R3: The encoded year is the two-digit value year − 2000 for years from 2000 upward, and year − 1900 for earlier years.
- R4: `month_i` counts from 0 (January) and is encoded as the one-based month. A `month_i` of 12 or more is an error.
- R5: A day of 0 is an error. A day beyond the month length is also an error, where the lengths from January on are 31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31, and February has 29 days in a leap year.
- R6: A year is a leap year when it divides by 400, or when it divides by 4 but not by 100. So 2000 and 2024 allow 29 February, and 2001 and 2023 do not.
- R7: An hour of 24 or more, a minute of 60 or more, or a second of 60 or more is an error.
- R8: Each encoded field is packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0].
- R9: On an error, `enc_err_o` and `enc_valid_o` are high for that one result cycle, and all six BCD outputs keep their previous values. In idle cycles the BCD outputs also hold and `enc_err_o` is low.
- R10: On decode, a two-digit BCD year of 69 or less gives 2000 plus that value, and anything higher gives 1900 plus that value.
- R11: On decode, the BCD month minus one is returned as the zero-based month. Day, hour, minute and second are returned as their binary values. Decode outputs hold between strobes.
- R12: After reset, both valid outputs and the error flag are low, and every BCD and decoded output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied on the clock edge |
| enc_valid_i | input | 1 | Encode strobe |
| year_i | input | 12 | Full binary year |
| month_i | input | 4 | Zero-based month |
| day_i | input | 5 | Day of month |
| hour_i | input | 5 | Hour, 0 to 23 |
| min_i | input | 6 | Minute |
| sec_i | input | 6 | Second |
| enc_valid_o | output | 1 | Encode result valid |
| enc_err_o | output | 1 | Encode input was illegal |
| bcd_year_o | output | 8 | Two-digit BCD year |
| bcd_month_o | output | 8 | BCD month, 1 to 12 |
| bcd_day_o | output | 8 | BCD day |
| bcd_hour_o | output | 8 | BCD hour |
| bcd_min_o | output | 8 | BCD minute |
| bcd_sec_o | output | 8 | BCD second |
| dec_valid_i | input | 1 | Decode strobe |
| dec_year_i | input | 8 | Two-digit BCD year |
| dec_month_i | input | 8 | BCD month, one-based |
| dec_day_i | input | 8 | BCD day |
| dec_hour_i | input | 8 | BCD hour |
| dec_min_i | input | 8 | BCD minute |
| dec_sec_i | input | 8 | BCD second |
| dec_valid_o | output | 1 | Decode result valid |
| dec_year_o | output | 12 | Full binary year |
| dec_month_o | output | 4 | Zero-based month |
| dec_day_o | output | 5 | Binary day |
| dec_hour_o | output | 5 | Binary hour |
| dec_min_o | output | 6 | Binary minute |
| dec_sec_o | output | 6 | Binary second |

## Verification
The assertions check several properties on every cycle. The valid outputs follow their strobes one cycle later. The error flag never appears without a valid output. The BCD outputs stay stable on error and idle cycles. Every accepted result has both digits in the 0 to 9 range. An out-of-range year or hour always produces an error, and a low two-digit year always decodes into the 2000s.

Only the bench scenarios can confirm the exact values. These include the month-length table and its leap-year exception, the boundary years 1970 and 2069, the century fold, and the decoded binary values.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int YEAR_W     = 12;
    localparam int YEAR_LO    = 1970;
    localparam int YEAR_HI    = 2069;
    localparam int CENT_HI    = 2000;
    localparam int CENT_LO    = 1900;
    localparam int YY_PIVOT   = 69;
    localparam int NFIELD     = 6;
    localparam int BIN_W      = 7;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;

    typedef logic [7:0]       bcd8_t;
    typedef logic [BIN_W-1:0] bin7_t;

    typedef struct packed {
        logic                   valid;
        logic                   err;
        bcd8_t [NFIELD-1:0]     bcd;
    } enc_state_t;

    typedef struct packed {
        logic              valid;
        logic [YEAR_W-1:0] year;
        logic [3:0]        mon;
        logic [4:0]        day;
        logic [4:0]        hour;
        logic [5:0]        min;
        logic [5:0]        sec;
    } dec_state_t;

    // Days in a one-based month; zero for anything outside 1..12.
    function automatic logic [4:0] month_days(input logic [4:0] m1, input logic leap);
        logic [4:0] n;
        case (m1)
            5'd1, 5'd3, 5'd5, 5'd7, 5'd8, 5'd10, 5'd12: n = 5'd31;
            5'd4, 5'd6, 5'd9, 5'd11:                   n = 5'd30;
            5'd2:                                      n = leap ? 5'd29 : 5'd28;
            default:                                   n = 5'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cal_limits_check.sv
module cal_limits_check
    import cal_pkg::*;
#(
    parameter int Y_W   = YEAR_W,
    parameter int Y_LO  = YEAR_LO,
    parameter int Y_HI  = YEAR_HI
) (
    input  logic [Y_W-1:0] year,
    input  logic [3:0]     month0,
    input  logic [4:0]     day,
    input  logic [4:0]     hour,
    input  logic [5:0]     min,
    input  logic [5:0]     sec,
    output logic [4:0]     month1,
    output logic           leap,
    output logic           err
);
    logic [4:0] mlen;
    logic       bad_year;
    logic       bad_date;
    logic       bad_time;

    always_comb begin
        int y;
        y        = int'(year);
        leap     = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
        month1   = {1'b0, month0} + 5'd1;
        mlen     = month_days(month1, leap);
        bad_year = (y < Y_LO) || (y > Y_HI);
        bad_date = (month1 > 5'd12) || (day == 5'd0) || (day > mlen);
        bad_time = (hour >= 5'd24) || (min >= 6'd60) || (sec >= 6'd60);
        err      = bad_year || bad_date || bad_time;
    end

endmodule

// File: rtl/cal_bin2bcd.sv
module cal_bin2bcd
    import cal_pkg::*;
#(
    parameter int IN_W = BIN_W
) (
    input  logic [IN_W-1:0] bin,
    output logic [7:0]      bcd
);
    always_comb begin
        int v;
        v   = int'(bin) % 100;
        bcd = {4'(v / 10), 4'(v % 10)};
    end
endmodule

// File: rtl/cal_bcd2bin.sv
module cal_bcd2bin
    import cal_pkg::*;
#(
    parameter int OUT_W = BIN_W
) (
    input  logic [7:0]       bcd,
    output logic [OUT_W-1:0] bin
);
    always_comb begin
        int t;
        t   = int'(bcd[7:4]) * 10 + int'(bcd[3:0]);
        bin = OUT_W'(t);
    end
endmodule

// File: rtl/cal_bcd_codec.sv
module cal_bcd_codec
    import cal_pkg::*;
#(
    parameter int Y_W    = YEAR_W,
    parameter int Y_LO   = YEAR_LO,
    parameter int Y_HI   = YEAR_HI,
    parameter int PIVOT  = YY_PIVOT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enc_valid_i,
    input  logic [Y_W-1:0] year_i,
    input  logic [3:0]     month_i,
    input  logic [4:0]     day_i,
    input  logic [4:0]     hour_i,
    input  logic [5:0]     min_i,
    input  logic [5:0]     sec_i,
    output logic           enc_valid_o,
    output logic           enc_err_o,
    output logic [7:0]     bcd_year_o,
    output logic [7:0]     bcd_month_o,
    output logic [7:0]     bcd_day_o,
    output logic [7:0]     bcd_hour_o,
    output logic [7:0]     bcd_min_o,
    output logic [7:0]     bcd_sec_o,
    input  logic           dec_valid_i,
    input  logic [7:0]     dec_year_i,
    input  logic [7:0]     dec_month_i,
    input  logic [7:0]     dec_day_i,
    input  logic [7:0]     dec_hour_i,
    input  logic [7:0]     dec_min_i,
    input  logic [7:0]     dec_sec_i,
    output logic           dec_valid_o,
    output logic [Y_W-1:0] dec_year_o,
    output logic [3:0]     dec_month_o,
    output logic [4:0]     dec_day_o,
    output logic [4:0]     dec_hour_o,
    output logic [5:0]     dec_min_o,
    output logic [5:0]     dec_sec_o
);

    // ---------------- encode path ----------------
    logic [4:0] month1;
    logic       leap_yr;
    logic       in_err;
    bin7_t      enc_bin [NFIELD];
    bcd8_t      enc_bcd [NFIELD];

    cal_limits_check #(.Y_W(Y_W), .Y_LO(Y_LO), .Y_HI(Y_HI)) u_check (
        .year   (year_i),
        .month0 (month_i),
        .day    (day_i),
        .hour   (hour_i),
        .min    (min_i),
        .sec    (sec_i),
        .month1 (month1),
        .leap   (leap_yr),
        .err    (in_err)
    );

    always_comb begin
        int y;
        int yy;
        y  = int'(year_i);
        yy = (y >= CENT_HI) ? (y - CENT_HI) : (y - CENT_LO);
        enc_bin[F_SEC]  = bin7_t'(sec_i);
        enc_bin[F_MIN]  = bin7_t'(min_i);
        enc_bin[F_HOUR] = bin7_t'(hour_i);
        enc_bin[F_DAY]  = bin7_t'(day_i);
        enc_bin[F_MON]  = bin7_t'(month1);
        enc_bin[F_YEAR] = bin7_t'(yy);
    end

    for (genvar gi = 0; gi < NFIELD; gi++) begin : g_enc
        cal_bin2bcd #(.IN_W(BIN_W)) u_b2b (
            .bin (enc_bin[gi]),
            .bcd (enc_bcd[gi])
        );
    end

    enc_state_t enc_d, enc_q;

    always_comb begin
        enc_d       = enc_q;
        enc_d.valid = enc_valid_i;
        enc_d.err   = enc_valid_i && in_err;
        if (enc_valid_i && !in_err) begin
            for (int k = 0; k < NFIELD; k++) enc_d.bcd[k] = enc_bcd[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) enc_q <= '0;
        else        enc_q <= enc_d;
    end

    assign enc_valid_o = enc_q.valid;
    assign enc_err_o   = enc_q.err;
    assign bcd_sec_o   = enc_q.bcd[F_SEC];
    assign bcd_min_o   = enc_q.bcd[F_MIN];
    assign bcd_hour_o  = enc_q.bcd[F_HOUR];
    assign bcd_day_o   = enc_q.bcd[F_DAY];
    assign bcd_month_o = enc_q.bcd[F_MON];
    assign bcd_year_o  = enc_q.bcd[F_YEAR];

    // ---------------- decode path ----------------
    bcd8_t dec_bcd [NFIELD];
    bin7_t dec_bin [NFIELD];

    always_comb begin
        dec_bcd[F_SEC]  = dec_sec_i;
        dec_bcd[F_MIN]  = dec_min_i;
        dec_bcd[F_HOUR] = dec_hour_i;
        dec_bcd[F_DAY]  = dec_day_i;
        dec_bcd[F_MON]  = dec_month_i;
        dec_bcd[F_YEAR] = dec_year_i;
    end

    for (genvar gj = 0; gj < NFIELD; gj++) begin : g_dec
        cal_bcd2bin #(.OUT_W(BIN_W)) u_b2n (
            .bcd (dec_bcd[gj]),
            .bin (dec_bin[gj])
        );
    end

    dec_state_t dec_d, dec_q;

    always_comb begin
        int yy;
        dec_d       = dec_q;
        dec_d.valid = dec_valid_i;
        yy          = int'(dec_bin[F_YEAR]);
        if (dec_valid_i) begin
            dec_d.year = Y_W'((yy <= PIVOT) ? (CENT_HI + yy) : (CENT_LO + yy));
            dec_d.mon  = 4'(dec_bin[F_MON] - bin7_t'(1));
            dec_d.day  = 5'(dec_bin[F_DAY]);
            dec_d.hour = 5'(dec_bin[F_HOUR]);
            dec_d.min  = 6'(dec_bin[F_MIN]);
            dec_d.sec  = 6'(dec_bin[F_SEC]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid_o = dec_q.valid;
    assign dec_year_o  = dec_q.year;
    assign dec_month_o = dec_q.mon;
    assign dec_day_o   = dec_q.day;
    assign dec_hour_o  = dec_q.hour;
    assign dec_min_o   = dec_q.min;
    assign dec_sec_o   = dec_q.sec;

    // ---------------- assertions ----------------
    assert_enc_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o);
    assert_enc_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> !enc_valid_o);
    assert_dec_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);
    assert_year_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid_i && ((int'(year_i) < Y_LO) || (int'(year_i) > Y_HI))) |=> enc_err_o);
    assert_hour_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid_i && (hour_i >= 5'd24)) |=> enc_err_o);
    assert_err_has_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        enc_err_o |-> enc_valid_o);
    assert_hold_bcd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enc_valid_o || enc_err_o) |-> ($stable(bcd_year_o) && $stable(bcd_month_o) &&
            $stable(bcd_day_o) && $stable(bcd_hour_o) && $stable(bcd_min_o) && $stable(bcd_sec_o)));
    assert_month_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid_o && !enc_err_o) |-> (bcd_month_o >= 8'h01 && bcd_month_o <= 8'h12));
    assert_dec_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && dec_year_i <= 8'h69) |=> (int'(dec_year_o) >= CENT_HI));

    for (genvar ga = 0; ga < NFIELD; ga++) begin : g_digit_chk
        assert_bcd_digits_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (enc_valid_o && !enc_err_o) |->
                (enc_q.bcd[ga][3:0] <= 4'd9 && enc_q.bcd[ga][7:4] <= 4'd9));
    end

endmodule

// File: tb/cal_bcd_codec_test.sv
module cal_bcd_codec_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_valid_i = 1'b0;
    logic [11:0] year_i = '0;
    logic [3:0]  month_i = '0;
    logic [4:0]  day_i = '0;
    logic [4:0]  hour_i = '0;
    logic [5:0]  min_i = '0;
    logic [5:0]  sec_i = '0;
    logic        enc_valid_o, enc_err_o;
    logic [7:0]  bcd_year_o, bcd_month_o, bcd_day_o, bcd_hour_o, bcd_min_o, bcd_sec_o;
    logic        dec_valid_i = 1'b0;
    logic [7:0]  dec_year_i = '0, dec_month_i = '0, dec_day_i = '0;
    logic [7:0]  dec_hour_i = '0, dec_min_i = '0, dec_sec_i = '0;
    logic        dec_valid_o;
    logic [11:0] dec_year_o;
    logic [3:0]  dec_month_o;
    logic [4:0]  dec_day_o, dec_hour_o;
    logic [5:0]  dec_min_o, dec_sec_o;

    always #2.5 clk = ~clk;

    cal_bcd_codec uut (
        .clk(clk), .rst_n(rst_n),
        .enc_valid_i(enc_valid_i), .year_i(year_i), .month_i(month_i), .day_i(day_i),
        .hour_i(hour_i), .min_i(min_i), .sec_i(sec_i),
        .enc_valid_o(enc_valid_o), .enc_err_o(enc_err_o),
        .bcd_year_o(bcd_year_o), .bcd_month_o(bcd_month_o), .bcd_day_o(bcd_day_o),
        .bcd_hour_o(bcd_hour_o), .bcd_min_o(bcd_min_o), .bcd_sec_o(bcd_sec_o),
        .dec_valid_i(dec_valid_i), .dec_year_i(dec_year_i), .dec_month_i(dec_month_i),
        .dec_day_i(dec_day_i), .dec_hour_i(dec_hour_i), .dec_min_i(dec_min_i), .dec_sec_i(dec_sec_i),
        .dec_valid_o(dec_valid_o), .dec_year_o(dec_year_o), .dec_month_o(dec_month_o),
        .dec_day_o(dec_day_o), .dec_hour_o(dec_hour_o), .dec_min_o(dec_min_o), .dec_sec_o(dec_sec_o)
    );

    int checks = 0;
    int bad = 0;

    // reference model state
    int m_ev = 0, m_err = 0;
    int m_bcd [6] = '{0, 0, 0, 0, 0, 0};   // sec, min, hour, day, month, year
    int m_dv = 0, m_dy = 0, m_dm = 0, m_dd = 0, m_dh = 0, m_dmi = 0, m_ds = 0;
    string cur_tag = "R1";

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_leap(int y);
        return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    endfunction

    function automatic int days_of(int y, int m1);
        int t [12] = '{31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31};
        if (m1 < 1 || m1 > 12) return 0;
        if (m1 == 2 && is_leap(y)) return 29;
        return t[m1-1];
    endfunction

    function automatic int to_bcd(int v);
        return (v / 10) * 16 + (v % 10);
    endfunction

    function automatic int from_bcd(int b);
        return (b / 16) * 10 + (b % 16);
    endfunction

    task automatic compare_all();
        chk("R1", int'(enc_valid_o), m_ev);
        chk(cur_tag, int'(enc_err_o), m_err);
        chk(m_err != 0 ? "R9" : cur_tag, int'(bcd_sec_o),   m_bcd[0]);
        chk(m_err != 0 ? "R9" : cur_tag, int'(bcd_min_o),   m_bcd[1]);
        chk(m_err != 0 ? "R9" : cur_tag, int'(bcd_hour_o),  m_bcd[2]);
        chk(m_err != 0 ? "R9" : cur_tag, int'(bcd_day_o),   m_bcd[3]);
        chk(m_err != 0 ? "R9" : cur_tag, int'(bcd_month_o), m_bcd[4]);
        chk(m_err != 0 ? "R9" : "R3",    int'(bcd_year_o),  m_bcd[5]);
        chk("R1",  int'(dec_valid_o), m_dv);
        chk("R10", int'(dec_year_o),  m_dy);
        chk("R11", int'(dec_month_o), m_dm);
        chk("R11", int'(dec_day_o),   m_dd);
        chk("R11", int'(dec_hour_o),  m_dh);
        chk("R11", int'(dec_min_o),   m_dmi);
        chk("R11", int'(dec_sec_o),   m_ds);
    endtask

    // one clock: model takes the inputs present at the edge, outputs compared after it
    task automatic tick();
        @(posedge clk);
        m_ev  = int'(enc_valid_i);
        m_err = 0;
        if (enc_valid_i) begin
            int y, m1, d, h, mi, s, e;
            y = int'(year_i); m1 = int'(month_i) + 1; d = int'(day_i);
            h = int'(hour_i); mi = int'(min_i); s = int'(sec_i);
            e = (y < 1970 || y > 2069 || m1 > 12 || d == 0 || d > days_of(y, m1) ||
                 h >= 24 || mi >= 60 || s >= 60) ? 1 : 0;
            m_err = e;
            if (e == 0) begin
                m_bcd[0] = to_bcd(s);  m_bcd[1] = to_bcd(mi); m_bcd[2] = to_bcd(h);
                m_bcd[3] = to_bcd(d);  m_bcd[4] = to_bcd(m1);
                m_bcd[5] = to_bcd(y >= 2000 ? y - 2000 : y - 1900);
            end
        end
        m_dv = int'(dec_valid_i);
        if (dec_valid_i) begin
            int yy;
            yy    = from_bcd(int'(dec_year_i));
            m_dy  = (yy <= 69) ? 2000 + yy : 1900 + yy;
            m_dm  = (from_bcd(int'(dec_month_i)) - 1) & 15;
            m_dd  = from_bcd(int'(dec_day_i));
            m_dh  = from_bcd(int'(dec_hour_i));
            m_dmi = from_bcd(int'(dec_min_i));
            m_ds  = from_bcd(int'(dec_sec_i));
        end
        #1;
        compare_all();
        @(negedge clk);
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
    endtask

    task automatic enc(int y, int m0, int d, int h, int mi, int s, string tag);
        year_i = 12'(y); month_i = 4'(m0); day_i = 5'(d);
        hour_i = 5'(h); min_i = 6'(mi); sec_i = 6'(s);
        enc_valid_i = 1'b1;
        cur_tag = tag;
        tick();
    endtask

    task automatic dec(int yb, int mb, int db, int hb, int mib, int sb);
        dec_year_i = 8'(yb); dec_month_i = 8'(mb); dec_day_i = 8'(db);
        dec_hour_i = 8'(hb); dec_min_i = 8'(mib); dec_sec_i = 8'(sb);
        dec_valid_i = 1'b1;
        tick();
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R12: reset state
        repeat (3) @(posedge clk);
        #1;
        cur_tag = "R12";
        compare_all();
        chk("R12", int'(enc_err_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R3 R8: normal encodes and century fold
        enc(2024, 2, 15, 10, 20, 30, "R8");
        enc(1970, 0, 1, 0, 0, 0, "R3");
        enc(2069, 11, 31, 23, 59, 59, "R3");
        enc(1999, 11, 31, 9, 5, 7, "R3");
        enc(2000, 0, 1, 12, 34, 56, "R3");
        // R2: year bounds, with holds checked against R9
        enc(1969, 5, 10, 1, 1, 1, "R2");
        enc(2070, 5, 10, 1, 1, 1, "R2");
        enc(0, 0, 1, 0, 0, 0, "R2");
        // R4: month bounds
        enc(2010, 12, 1, 0, 0, 0, "R4");
        enc(2010, 15, 1, 0, 0, 0, "R4");
        enc(2010, 11, 1, 0, 0, 0, "R4");
        // R6: leap years
        enc(2000, 1, 29, 0, 0, 0, "R6");
        enc(2004, 1, 29, 0, 0, 0, "R6");
        enc(2001, 1, 29, 0, 0, 0, "R6");
        enc(2023, 1, 29, 0, 0, 0, "R6");
        // R5: day of zero and every month length in a common and a leap year
        enc(2015, 6, 0, 0, 0, 0, "R5");
        for (int yi = 0; yi < 2; yi++) begin
            for (int mm = 0; mm < 12; mm++) begin
                int yr;
                yr = (yi == 0) ? 2023 : 2024;
                enc(yr, mm, days_of(yr, mm + 1), 1, 2, 3, "R5");
                enc(yr, mm, days_of(yr, mm + 1) + 1, 1, 2, 3, "R5");
            end
        end
        // R7: time limits
        enc(2030, 3, 3, 24, 0, 0, "R7");
        enc(2030, 3, 3, 0, 60, 0, "R7");
        enc(2030, 3, 3, 0, 0, 60, "R7");
        enc(2030, 3, 3, 31, 63, 63, "R7");
        enc(2030, 3, 3, 23, 59, 59, "R7");
        // R9: idle cycles hold, error between good results
        tick();
        tick();
        enc(2011, 6, 6, 6, 6, 6, "R9");
        enc(2011, 1, 30, 6, 6, 6, "R9");
        enc(2012, 7, 7, 7, 7, 7, "R9");
        // R10 R11: decode
        dec('h69, 'h12, 'h31, 'h23, 'h59, 'h59);
        dec('h70, 'h01, 'h01, 'h00, 'h00, 'h00);
        dec('h00, 'h02, 'h29, 'h12, 'h30, 'h45);
        dec('h99, 'h10, 'h15, 'h07, 'h08, 'h09);
        tick();
        dec('h24, 'h06, 'h18, 'h19, 'h41, 'h17);
        // both paths at once
        year_i = 12'd2048; month_i = 4'd8; day_i = 5'd30; hour_i = 5'd4; min_i = 6'd44; sec_i = 6'd22;
        enc_valid_i = 1'b1;
        cur_tag = "R1";
        dec_year_i = 8'h48; dec_month_i = 8'h09; dec_day_i = 8'h30;
        dec_hour_i = 8'h04; dec_min_i = 8'h44; dec_sec_i = 8'h22;
        dec_valid_i = 1'b1;
        tick();
        tick();
        summary();
    end

endmodule